// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block is a synchronous controller placed between a simple 32-bit write port and a small on-chip flash array. The array is modelled as register storage. The host enters operations as fixed series of bus writes. Each write is an address/data pair. A write that breaks a series abandons it, and the controller returns to read mode.

Two operations exist. Page program takes one whole page, one 32-bit word per write. Programming can only clear bits, so each stored word becomes the old word ANDed with the written word. A page may be programmed only once after each erase. Chip erase returns every word of every unlocked block to all-ones and leaves locked blocks alone. A per-block lock input guards both operations. Reads run on a separate registered port at all times.

Geometry: 8 words per page, 4 pages per block and 4 blocks, which gives 128 words. Array word index `i` lies in page `i[6:3]` and in block `i[6:5]`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` and `err` are 0, every array word reads 0xFFFFFFFF and every page counts as erased.
- R2: The series 0x555/0x000000AA, 0x2AA/0x00000055, 0x555/0x000000A0 opens a page program. The fourth write gives the page, taken from address bits [6:3], and data word 0. The next seven writes give words 1 to 7 in order, and their addresses are ignored. After the eighth data word, no further write is taken into that page.
- R3: Programming never sets a bit. The stored word becomes the old word AND the written word, so a written 0xFFFFFFFF leaves its word unchanged.
- R4: A fourth write that names a page programmed since its last erase sets `err`, and the array is left unchanged.
- R5: A fourth write that names a page in a block whose `blk_lock` bit is 1 sets `err`, and the array is left unchanged.
- R6: A fourth write whose address bits [2:0] are not zero sets `err`, and the array is left unchanged.
- R7: The series 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10, placed after the first two unlock writes, starts chip erase. Chip erase sets every word of every unlocked block to 0xFFFFFFFF, leaves locked blocks as they were, and marks the pages of unlocked blocks as erased.
- R8: If every `blk_lock` bit is 1 when the erase series completes, no erase runs, `busy` stays 0 and the controller is back in read mode.
- R9: A write that does not match the next expected step of a series abandons the series. That write is not taken as the start of a new series.
- R10: `busy` rises in the cycle after the final write of an operation. It stays high for 8 cycles for a program and for 128 cycles for an erase. Bus writes while `busy` is high are ignored.
- R11: `err` stays set until the third write of a program series, or the sixth write of an erase series, is accepted. That write clears it.
- R12: `rd_data` shows the word at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Write address |
| bus_wdata | input | 32 | Write data |
| blk_lock | input | 4 | Per-block lock, 1 = protected |
| rd_addr | input | 7 | Array read word index |
| rd_data | output | 32 | Registered read data |
| busy | output | 1 | An operation is running |
| err | output | 1 | The last program attempt was refused |

## Verification
The bench's reference model advances on the same clock edge as the design. The error flag is due in the cycle after the fourth write. `busy` is due in the cycle after the final write, and it falls after exactly 8 or 128 further edges. The array contents are due one edge after `rd_addr` is presented. The model stops predicting read data while an operation is running. It resumes at the first edge after `busy` falls, when the complete result is due. Directed checks sample at falling edges, so each sample falls after the register that produces the value.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    parameter int DATA_W        = 32;
    parameter int ADDR_W        = 12;
    parameter int PAGE_WORDS    = 8;
    parameter int PAGES_PER_BLK = 4;
    parameter int NUM_BLKS      = 4;

    localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
    localparam int NUM_WORDS = PAGE_WORDS * NUM_PAGES;
    localparam int BLK_WORDS = PAGE_WORDS * PAGES_PER_BLK;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int PIDX_W    = $clog2(NUM_PAGES);
    localparam int OFS_W     = $clog2(PAGE_WORDS);
    localparam int BIDX_W    = $clog2(NUM_BLKS);

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(12'h2AA);
    localparam logic [DATA_W-1:0] KEY_UNL1   = DATA_W'(32'hAA);
    localparam logic [DATA_W-1:0] KEY_UNL2   = DATA_W'(32'h55);
    localparam logic [DATA_W-1:0] KEY_PROG   = DATA_W'(32'hA0);
    localparam logic [DATA_W-1:0] KEY_ERSETUP= DATA_W'(32'h80);
    localparam logic [DATA_W-1:0] KEY_ERGO   = DATA_W'(32'h10);

    typedef enum logic [2:0] {
        SQ_READ, SQ_KEY1, SQ_KEY2, SQ_PG_BASE, SQ_PG_FILL,
        SQ_ER_KEY1, SQ_ER_KEY2, SQ_ER_KEY3
    } seq_state_t;

    typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE} exec_op_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic step_hit(input bus_wr_t w,
                                      input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

    function automatic logic [BIDX_W-1:0] blk_of_page(input logic [PIDX_W-1:0] p);
        return BIDX_W'(int'(p) / PAGES_PER_BLK);
    endfunction

    function automatic logic [BIDX_W-1:0] blk_of_word(input logic [WIDX_W-1:0] w);
        return BIDX_W'(int'(w) / BLK_WORDS);
    endfunction
endpackage

// File: rtl/fseq_array.sv
module fseq_array
    import fseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WIDX_W-1:0]     waddr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  clr_en,
    input  logic [PIDX_W-1:0]     clr_page,
    input  logic [NUM_PAGES-1:0]  set_mask,
    input  logic [NUM_BLKS-1:0]   blk_lock,
    input  logic [WIDX_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     cur_word,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_PAGES-1:0]  page_erased
);
    logic [DATA_W-1:0] cells [NUM_WORDS];

    assign cur_word = cells[waddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) cells[i] <= '1;
            rd_data <= '0;
        end else begin
            if (we) cells[waddr] <= wdata;
            rd_data <= cells[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_erased <= '1;
        end else begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                if (set_mask[p]) page_erased[p] <= 1'b1;
                else if (clr_en && (clr_page == PIDX_W'(p))) page_erased[p] <= 1'b0;
            end
        end
    end

    // R5 / R7: no write ever lands in a locked block
    p_locked_untouched_r5: assert property (@(posedge clk) disable iff (rst)
        we |-> !blk_lock[blk_of_word(waddr)]);

    // R4: a program only completes on a page that was erased
    p_prog_once_r4: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> page_erased[clr_page]);
endmodule

// File: rtl/fseq_cmd.sv
module fseq_cmd
    import fseq_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  bus_wr_t                              wr,
    input  logic                                 busy,
    input  logic [NUM_BLKS-1:0]                  blk_lock,
    input  logic [NUM_PAGES-1:0]                 page_erased,
    output logic                                 go_prog,
    output logic                                 go_erase,
    output logic [PIDX_W-1:0]                    go_page,
    output logic [PAGE_WORDS-1:0][DATA_W-1:0]    page_buf,
    output logic                                 err
);
    seq_state_t                st_q, st_n;
    logic [OFS_W-1:0]          ofs_q;
    logic [PIDX_W-1:0]         page_q;
    logic                      err_q;
    logic                      take, cap, err_set, err_clr;
    logic [PIDX_W-1:0]         wr_page;
    logic                      base_bad;

    assign take    = wr.we && !busy;
    assign wr_page = wr.addr[WIDX_W-1:OFS_W];
    assign base_bad = (wr.addr[OFS_W-1:0] != '0) ||
                      blk_lock[blk_of_page(wr_page)] ||
                      !page_erased[wr_page];

    always_comb begin
        st_n     = st_q;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        cap      = 1'b0;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        if (take) begin
            unique case (st_q)
                SQ_READ:    st_n = step_hit(wr, KEY_ADDR_A, KEY_UNL1) ? SQ_KEY1 : SQ_READ;
                SQ_KEY1:    st_n = step_hit(wr, KEY_ADDR_B, KEY_UNL2) ? SQ_KEY2 : SQ_READ;
                SQ_KEY2: begin
                    if (step_hit(wr, KEY_ADDR_A, KEY_PROG)) begin
                        st_n    = SQ_PG_BASE;
                        err_clr = 1'b1;
                    end else if (step_hit(wr, KEY_ADDR_A, KEY_ERSETUP)) begin
                        st_n = SQ_ER_KEY1;
                    end else begin
                        st_n = SQ_READ;
                    end
                end
                SQ_PG_BASE: begin
                    if (base_bad) begin
                        err_set = 1'b1;
                        st_n    = SQ_READ;
                    end else begin
                        cap  = 1'b1;
                        st_n = SQ_PG_FILL;
                    end
                end
                SQ_PG_FILL: begin
                    cap = 1'b1;
                    if (ofs_q == OFS_W'(PAGE_WORDS - 1)) begin
                        go_prog = 1'b1;
                        st_n    = SQ_READ;
                    end
                end
                SQ_ER_KEY1: st_n = step_hit(wr, KEY_ADDR_A, KEY_UNL1) ? SQ_ER_KEY2 : SQ_READ;
                SQ_ER_KEY2: st_n = step_hit(wr, KEY_ADDR_B, KEY_UNL2) ? SQ_ER_KEY3 : SQ_READ;
                SQ_ER_KEY3: begin
                    if (step_hit(wr, KEY_ADDR_A, KEY_ERGO)) begin
                        err_clr  = 1'b1;
                        go_erase = !(&blk_lock);
                    end
                    st_n = SQ_READ;
                end
                default:    st_n = SQ_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_READ;
            ofs_q  <= '0;
            page_q <= '0;
            err_q  <= 1'b0;
            page_buf <= '0;
        end else begin
            st_q <= st_n;
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
            if (cap) begin
                if (st_q == SQ_PG_BASE) begin
                    page_buf[0] <= wr.data;
                    page_q      <= wr_page;
                    ofs_q       <= OFS_W'(1);
                end else begin
                    page_buf[ofs_q] <= wr.data;
                    ofs_q           <= ofs_q + OFS_W'(1);
                end
            end
        end
    end

    assign go_page = page_q;
    assign err     = err_q;

    // R10: no operation is launched while one is running
    p_no_launch_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(go_prog || go_erase));

    // R11: a completed erase series leaves the error flag clear
    p_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
        go_erase |=> !err);
endmodule

// File: rtl/fseq_exec.sv
module fseq_exec
    import fseq_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 go_prog,
    input  logic                                 go_erase,
    input  logic [PIDX_W-1:0]                    go_page,
    input  logic [PAGE_WORDS-1:0][DATA_W-1:0]    page_buf,
    input  logic [NUM_BLKS-1:0]                  blk_lock,
    input  logic [DATA_W-1:0]                    cur_word,
    output logic                                 busy,
    output logic                                 arr_we,
    output logic [WIDX_W-1:0]                    arr_waddr,
    output logic [DATA_W-1:0]                    arr_wdata,
    output logic                                 clr_en,
    output logic [PIDX_W-1:0]                    clr_page,
    output logic [NUM_PAGES-1:0]                 set_mask
);
    exec_op_t            op_q;
    logic                active_q;
    logic [WIDX_W-1:0]   idx_q;
    logic [PIDX_W-1:0]   page_q;
    logic                last;
    logic [NUM_PAGES-1:0] free_pages;

    always_comb begin
        for (int p = 0; p < NUM_PAGES; p++)
            free_pages[p] = !blk_lock[blk_of_page(PIDX_W'(p))];
    end

    always_comb begin
        if (op_q == OP_PROG) begin
            arr_waddr = {page_q, idx_q[OFS_W-1:0]};
            arr_wdata = cur_word & page_buf[idx_q[OFS_W-1:0]];
            arr_we    = active_q;
            last      = (idx_q[OFS_W-1:0] == OFS_W'(PAGE_WORDS - 1));
        end else begin
            arr_waddr = idx_q;
            arr_wdata = '1;
            arr_we    = active_q && !blk_lock[blk_of_word(idx_q)];
            last      = (idx_q == WIDX_W'(NUM_WORDS - 1));
        end
    end

    assign busy     = active_q;
    assign clr_en   = active_q && (op_q == OP_PROG) && last;
    assign clr_page = page_q;
    assign set_mask = (active_q && (op_q == OP_ERASE) && last) ? free_pages : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= OP_IDLE;
            idx_q    <= '0;
            page_q   <= '0;
        end else if (!active_q) begin
            if (go_prog || go_erase) begin
                active_q <= 1'b1;
                op_q     <= go_prog ? OP_PROG : OP_ERASE;
                idx_q    <= '0;
                page_q   <= go_page;
            end
        end else if (last) begin
            active_q <= 1'b0;
            op_q     <= OP_IDLE;
            idx_q    <= '0;
        end else begin
            idx_q <= idx_q + WIDX_W'(1);
        end
    end

    // R8: an erase is only launched when some block is unlocked
    p_erase_needs_free_r8: assert property (@(posedge clk) disable iff (rst)
        go_erase |-> !(&blk_lock));

    // R10: a launch raises busy on the next cycle
    p_launch_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (go_prog || go_erase) |=> busy);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_BLKS-1:0]  blk_lock,
    input  logic [WIDX_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 err
);
    bus_wr_t                              wr;
    logic                                 go_prog, go_erase;
    logic [PIDX_W-1:0]                    go_page;
    logic [PAGE_WORDS-1:0][DATA_W-1:0]    page_buf;
    logic [NUM_PAGES-1:0]                 page_erased, set_mask;
    logic                                 arr_we, clr_en;
    logic [WIDX_W-1:0]                    arr_waddr;
    logic [DATA_W-1:0]                    arr_wdata, cur_word;
    logic [PIDX_W-1:0]                    clr_page;

    assign wr = '{we: bus_we, addr: bus_addr, data: bus_wdata};

    fseq_cmd u_cmd (
        .clk(clk), .rst(rst), .wr(wr), .busy(busy), .blk_lock(blk_lock),
        .page_erased(page_erased), .go_prog(go_prog), .go_erase(go_erase),
        .go_page(go_page), .page_buf(page_buf), .err(err)
    );

    fseq_exec u_exec (
        .clk(clk), .rst(rst), .go_prog(go_prog), .go_erase(go_erase),
        .go_page(go_page), .page_buf(page_buf), .blk_lock(blk_lock),
        .cur_word(cur_word), .busy(busy), .arr_we(arr_we),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .clr_en(clr_en),
        .clr_page(clr_page), .set_mask(set_mask)
    );

    fseq_array u_array (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .clr_en(clr_en), .clr_page(clr_page),
        .set_mask(set_mask), .blk_lock(blk_lock), .rd_addr(rd_addr),
        .cur_word(cur_word), .rd_data(rd_data), .page_erased(page_erased)
    );
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  blk_lock = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy, err;

    int checks = 0;
    int errors = 0;

    flash_cmd_seq u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .blk_lock(blk_lock), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .err(err)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0] m_mem [128];
    bit          m_erased [16];
    int          m_busy, m_op, m_page, m_phase;
    bit          m_err, m_rd_ok;
    logic [31:0] m_exp_rd;
    logic [31:0] m_buf [$];
    int          m_qa [$];
    int          m_qd [$];
    int          key_a [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h555};
    int          pkey_d[3] = '{'hAA, 'h55, 'hA0};
    int          ekey_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h10};

    task automatic m_apply();
        if (m_op == 1) begin
            for (int i = 0; i < 8; i++) m_mem[m_page*8+i] = m_mem[m_page*8+i] & m_buf[i];
            m_erased[m_page] = 0;
        end else begin
            for (int w = 0; w < 128; w++) if (!blk_lock[w/32]) m_mem[w] = 32'hFFFFFFFF;
            for (int p = 0; p < 16; p++) if (!blk_lock[p/4]) m_erased[p] = 1;
        end
        m_op = 0;
    endtask

    task automatic m_accept(input int a, input logic [31:0] d);
        if (m_phase == 2) begin
            m_buf.push_back(d);
            if (m_buf.size() == 8) begin m_busy = 8; m_op = 1; m_phase = 0; end
        end else if (m_phase == 1) begin
            int pg = (a >> 3) & 15;
            if ((a & 7) != 0 || blk_lock[pg/4] || !m_erased[pg]) begin
                m_err = 1; m_phase = 0;
            end else begin
                m_page = pg; m_buf = {}; m_buf.push_back(d); m_phase = 2;
            end
        end else begin
            bit is_p, is_e;
            int n;
            m_qa.push_back(a); m_qd.push_back(int'(d));
            n = m_qa.size();
            is_p = (n <= 3); is_e = (n <= 6);
            for (int i = 0; i < n; i++) begin
                if (is_p && (m_qa[i] != key_a[i] || m_qd[i] != pkey_d[i])) is_p = 0;
                if (is_e && (m_qa[i] != key_a[i] || m_qd[i] != ekey_d[i])) is_e = 0;
            end
            if (n == 3 && is_p) begin
                m_err = 0; m_phase = 1; m_qa = {}; m_qd = {};
            end else if (n == 6 && is_e) begin
                m_err = 0; m_qa = {}; m_qd = {};
                if (blk_lock != 4'hF) begin m_busy = 128; m_op = 2; end
            end else if (!(is_p || is_e)) begin
                m_qa = {}; m_qd = {};
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) m_mem[i] = 32'hFFFFFFFF;
            for (int p = 0; p < 16; p++) m_erased[p] = 1;
            m_busy = 0; m_op = 0; m_phase = 0; m_err = 0; m_rd_ok = 0;
            m_qa = {}; m_qd = {};
        end else begin
            m_exp_rd = m_mem[rd_addr];
            m_rd_ok  = (m_busy == 0);
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) m_apply();
            end else if (bus_we) begin
                m_accept(int'(bus_addr), bus_wdata);
            end
        end
    end

    // per-clock comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (busy !== (m_busy > 0)) begin
                errors++;
                $display("FAIL R10 busy: got %0b expected %0b at %0t", busy, m_busy > 0, $time);
            end
            checks++;
            if (err !== m_err) begin
                errors++;
                $display("FAIL R11 err: got %0b expected %0b at %0t", err, m_err, $time);
            end
            if (m_rd_ok) begin
                checks++;
                if (rd_data !== m_exp_rd) begin
                    errors++;
                    $display("FAIL R12 rd_data: got %h expected %h at %0t", rd_data, m_exp_rd, $time);
                end
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic expect_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_word(input int a, output logic [31:0] v);
        @(negedge clk); rd_addr = 7'(a);
        @(negedge clk); v = rd_data;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (busy) begin cycles++; @(negedge clk); end
    endtask

    task automatic program_page(input logic [11:0] base, input logic [31:0] seed);
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'hA0);
        bw(base, seed);
        for (int i = 1; i < 8; i++) bw(12'h7F0 + 12'(i), seed ^ (32'h01010101 * 32'(i)));
        bus_idle();
    endtask

    task automatic chip_erase();
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'h80);
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'h10);
        bus_idle();
    endtask

    function automatic logic [31:0] pat(input logic [31:0] seed, input int i);
        return (i == 0) ? seed : seed ^ (32'h01010101 * 32'(i));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_val("R1 busy", {31'd0, busy}, 32'd0);
        expect_val("R1 err", {31'd0, err}, 32'd0);
        read_word(0, v);   expect_val("R1 word0", v, 32'hFFFFFFFF);
        read_word(127, v); expect_val("R1 word127", v, 32'hFFFFFFFF);

        // R2 / R3: program page 2, word 3 all-ones, junk addresses on data writes
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'hA0);
        bw(12'h010, 32'h12345678);
        for (int i = 1; i < 8; i++) bw(12'h3C0 + 12'(i), (i == 3) ? 32'hFFFFFFFF : 32'hA5A50000 + 32'(i));
        bus_idle();
        expect_val("R10 busy after last write", {31'd0, busy}, 32'd1);
        // R10: writes during busy ignored (a full program series)
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'hA0); bw(12'h020, 32'h0);
        bus_idle();
        wait_done(n);
        expect_val("R10 program busy length", 32'(n + 5), 32'd8);
        read_word(16, v); expect_val("R2 word0", v, 32'h12345678);
        read_word(23, v); expect_val("R2 word7", v, 32'hA5A50007);
        read_word(19, v); expect_val("R3 all-ones word unchanged", v, 32'hFFFFFFFF);
        read_word(32, v); expect_val("R10 ignored write page4", v, 32'hFFFFFFFF);
        read_word(24, v); expect_val("R2 no spill into page3", v, 32'hFFFFFFFF);

        // R4: second program on page 2
        program_page(12'h010, 32'h0);
        expect_val("R4 err set", {31'd0, err}, 32'd1);
        read_word(16, v); expect_val("R4 array unchanged", v, 32'h12345678);

        // R11: third write of a program series clears err
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'hA0);
        @(negedge clk); bus_we = 1'b0;
        expect_val("R11 err cleared", {31'd0, err}, 32'd0);
        bw(12'h028, 32'hF0F0F0F0);
        for (int i = 1; i < 8; i++) bw(12'h100, pat(32'hF0F0F0F0, i));
        bus_idle();
        wait_done(n);
        read_word(41, v); expect_val("R2 page5 word1", v, pat(32'hF0F0F0F0, 1));

        // R6: misaligned base
        program_page(12'h019, 32'h0);
        expect_val("R6 err set", {31'd0, err}, 32'd1);
        read_word(24, v); expect_val("R6 array unchanged", v, 32'hFFFFFFFF);

        // R7: erase with block 1 locked
        blk_lock = 4'b0010;
        chip_erase();
        wait_done(n);
        expect_val("R10 erase busy length", 32'(n), 32'd128);
        read_word(16, v); expect_val("R7 page2 erased", v, 32'hFFFFFFFF);
        read_word(41, v); expect_val("R7 locked page5 kept", v, pat(32'hF0F0F0F0, 1));

        // R5: program into locked block (page 6, never programmed)
        program_page(12'h030, 32'h0);
        expect_val("R5 err set", {31'd0, err}, 32'd1);
        read_word(48, v); expect_val("R5 array unchanged", v, 32'hFFFFFFFF);

        // R7: page 2 programmable again after erase
        program_page(12'h010, 32'h0F0F0F0F);
        wait_done(n);
        read_word(16, v); expect_val("R7 page2 reprogrammed", v, 32'h0F0F0F0F);

        // R9: broken series, then its remainder must not act
        bw(12'h555, 32'hAA); bw(12'h2AA, 32'h55); bw(12'h555, 32'h77);
        bw(12'h555, 32'hA0); bw(12'h040, 32'h0);
        for (int i = 1; i < 8; i++) bw(12'h041, 32'h0);
        bus_idle();
        expect_val("R9 no busy", {31'd0, busy}, 32'd0);
        read_word(64, v); expect_val("R9 array unchanged", v, 32'hFFFFFFFF);

        // R8: all blocks locked
        blk_lock = 4'hF;
        chip_erase();
        expect_val("R8 busy stays low", {31'd0, busy}, 32'd0);
        read_word(16, v); expect_val("R8 contents kept", v, 32'h0F0F0F0F);
        blk_lock = 4'h0;
        program_page(12'h040, 32'h00FF00FF);
        wait_done(n);
        read_word(64, v); expect_val("R8 read mode restored", v, 32'h00FF00FF);

        // full erase, unlocked
        chip_erase();
        wait_done(n);
        read_word(41, v); expect_val("R7 full erase page5", v, 32'hFFFFFFFF);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule